// File: doc/BRIEF.md
# Dual-Channel UART Interrupt Status and Mask

This block gathers the transmit-ready and receive-ready levels of two serial channels into one 8-bit interrupt status byte. A host reaches it through a small register bus: a read at the interrupt address returns the status byte, and a write at that same address loads an internally held 8-bit interrupt mask. The status byte and the mask are ANDed. When any bit survives, the shared interrupt request is driven low.

Each channel owns a 4-bit nibble. Channel x places transmit-ready at bit 4x and receive-ready at bit 4x+1. The two upper bits of each nibble belong to sources that this block does not build, and they read as zero. Status bits are live levels and are never latched: a bit clears as soon as its condition drops. The status read is raw, so it ignores the mask.

The request line is held by a two-state machine. `REQ_IDLE` drives the line high. `REQ_ACTIVE` drives it low. The transition `IDLE_TO_ACTIVE` is taken on a clock edge at which a masked source is pending. The transition `ACTIVE_TO_IDLE` is taken on an edge at which none is pending. In every other case the machine stays in its current state. Because the line is registered, it changes one clock after the status or the mask changes.

Top module: `uart_irq_hub`

## Requirements
- R1: After reset the request line `irq_n` is high and the mask is all zero, so no ready level pulls `irq_n` low until a mask is written.
- R2: A read (`bus_rd`=1) at address 5 returns the status byte: channel 0 transmit-ready at bit 0, channel 0 receive-ready at bit 1, channel 1 transmit-ready at bit 4, channel 1 receive-ready at bit 5.
- R3: Status bits 2, 3, 6 and 7 always read as zero.
- R4: The status read is raw: a ready level shows in its bit whether or not the mask bit is set.
- R5: Status bits are live levels: a bit reads 0 as soon as its source level is 0, with no clear action.
- R6: A write (`bus_wr`=1) at address 5 loads `bus_wdata` into the mask on that clock edge. A write at any other address leaves the mask unchanged.
- R7: `irq_n` is driven low on the clock edge after one at which some status bit and its mask bit are both 1. Mask bit positions match the status bit positions of R2.
- R8: With a mask of zero, `irq_n` stays high whatever the ready levels are.
- R9: `irq_n` returns high on the clock edge after one at which no masked status bit is 1.
- R10: A read at any address other than 5, or with `bus_rd`=0, returns zero on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ready | input | 2 | Transmit-ready level per channel |
| rx_ready | input | 2 | Receive-ready level per channel |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data (mask value) |
| bus_rdata | output | 8 | Read data (status byte or zero) |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- `irq_n` follows the masked status with one clock of latency, in both directions.
- A zero mask keeps `irq_n` high.
- The unused status bits stay zero.
- A write at the interrupt address lands in the mask.
- A read at the interrupt address reflects the raw ready levels.

Other behaviours need the directed scenarios of the bench:
- The reset state.
- The bit placement seen through full reads.
- Writes at other addresses having no effect on the mask.
- Reads at other addresses returning zero.
- The release of `irq_n` when a source level or a mask bit drops.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NUM_CH  = 2;
    localparam int NIB_W   = 4;
    localparam int STAT_W  = NUM_CH * NIB_W;
    localparam int TX_OFS  = 0;
    localparam int RX_OFS  = 1;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_t;
endpackage

// File: rtl/irq_status_gather.sv
module irq_status_gather
    import uart_irq_pkg::*;
(
    input  logic [NUM_CH-1:0] tx_ready,
    input  logic [NUM_CH-1:0] rx_ready,
    output logic [STAT_W-1:0] status
);
    // Build one nibble per channel; the upper two bits of each nibble are tied low.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_nib
        assign status[ch*NIB_W + TX_OFS] = tx_ready[ch];
        assign status[ch*NIB_W + RX_OFS] = rx_ready[ch];
        for (genvar b = 2; b < NIB_W; b++) begin : g_pad
            assign status[ch*NIB_W + b] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import uart_irq_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter logic [3:0]  IRQ_ADDR = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] mask_q
);
    logic hit_wr;
    assign hit_wr = bus_wr && (bus_addr == ADDR_W'(IRQ_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (hit_wr)  mask_q <= bus_wdata;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit_wr |=> (mask_q == $past(bus_wdata)));                        // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_W'(IRQ_ADDR)) |=> $stable(mask_q));  // R6
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] mask_q,
    output logic              irq_n
);
    req_state_t state_q, state_d;
    logic       pending;

    assign pending = |(status & mask_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (pending)  state_d = REQ_ACTIVE;  // IDLE_TO_ACTIVE
            REQ_ACTIVE: if (!pending) state_d = REQ_IDLE;    // ACTIVE_TO_IDLE
            default:                  state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            REQ_ACTIVE: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end

    AST_REQ_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & mask_q)) |=> !irq_n);                               // R7
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & mask_q)) |=> irq_n);                               // R9
    AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> irq_n);                                      // R8
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
    import uart_irq_pkg::*;
#(
    parameter int         ADDR_W   = 4,
    parameter logic [3:0] IRQ_ADDR = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tx_ready,
    input  logic [1:0]        rx_ready,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_n
);
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] mask_q;
    logic              hit_rd;

    irq_status_gather u_gather (
        .tx_ready (tx_ready),
        .rx_ready (rx_ready),
        .status   (status)
    );

    irq_mask_reg #(.ADDR_W(ADDR_W), .IRQ_ADDR(IRQ_ADDR)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .mask_q    (mask_q)
    );

    irq_req_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .mask_q (mask_q),
        .irq_n  (irq_n)
    );

    assign hit_rd    = bus_rd && (bus_addr == ADDR_W'(IRQ_ADDR));
    assign bus_rdata = hit_rd ? status : '0;

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[3:2] == 2'b00) && (bus_rdata[7:6] == 2'b00));        // R3
    AST_RAW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rd |-> (bus_rdata[0] == tx_ready[0]) && (bus_rdata[1] == rx_ready[0])
               && (bus_rdata[4] == tx_ready[1]) && (bus_rdata[5] == rx_ready[1])); // R2
    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_rd |-> (bus_rdata == 8'h00));                              // R10
endmodule

// File: tb/tb_uart_irq_hub.sv
module tb_uart_irq_hub;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tx_ready = '0;
    logic [1:0] rx_ready = '0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_hub dut (
        .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_status(input logic [1:0] t, input logic [1:0] r);
        return {2'b00, r[1], t[1], 2'b00, r[0], t[0]};
    endfunction

    // Write at negedge; the mask loads at the following posedge.
    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // Let one posedge pass so the request register sees the current state.
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        tx_ready = 2'b11; rx_ready = 2'b11;
        settle(); settle();
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        check("R8 zero mask blocks", {7'd0, irq_n}, 8'h01);
        rd_reg(4'h5, d);
        check("R3 unused bits zero", d & 8'hCC, 8'h00);
        tx_ready = '0; rx_ready = '0;
    endtask

    task automatic t_layout();
        logic [7:0] d;
        for (int i = 0; i < 16; i++) begin
            tx_ready = {i[2], i[0]}; rx_ready = {i[3], i[1]};
            #1 rd_reg(4'h5, d);
            check("R2 status layout", d, model_status(tx_ready, rx_ready));
        end
        tx_ready = 2'b01; rx_ready = 2'b00;
        #1 rd_reg(4'h5, d);
        check("R5 live level set", d, 8'h01);
        tx_ready = 2'b00;
        #1 rd_reg(4'h5, d);
        check("R5 live level clear", d, 8'h00);
        rx_ready = 2'b10;
        #1 rd_reg(4'h3, d);
        check("R10 other address reads zero", d, 8'h00);
        bus_addr = 4'h5; #1;
        check("R10 no strobe reads zero", bus_rdata, 8'h00);
        rx_ready = '0;
        @(negedge clk);
    endtask

    task automatic t_mask_irq();
        logic [7:0] d;
        wr_reg(4'h5, 8'h20);            // channel 1 receive-ready only
        tx_ready = 2'b11; rx_ready = 2'b01;
        settle();
        check("R7 unmasked sources quiet", {7'd0, irq_n}, 8'h01);
        rd_reg(4'h5, d);
        check("R4 raw status read", d, 8'h13);
        rx_ready = 2'b11;
        #1 check("R7 one-clock latency before edge", {7'd0, irq_n}, 8'h01);
        settle();
        check("R7 masked source asserts", {7'd0, irq_n}, 8'h00);
        rx_ready = 2'b01;
        settle();
        check("R9 release on source drop", {7'd0, irq_n}, 8'h01);
        rx_ready = 2'b11;
        settle();
        wr_reg(4'h6, 8'h00);            // other address: mask must stay
        settle();
        check("R6 write elsewhere ignored", {7'd0, irq_n}, 8'h00);
        wr_reg(4'h5, 8'h00);
        settle();
        check("R8 zero mask releases", {7'd0, irq_n}, 8'h01);
        wr_reg(4'h5, 8'h01);
        settle();
        check("R6 mask loaded ch0 tx", {7'd0, irq_n}, 8'h00);
        tx_ready = '0; rx_ready = '0;
        settle();
        check("R9 all clear releases", {7'd0, irq_n}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq_n high at reset", {7'd0, irq_n}, 8'h01);
        t_reset();
        t_layout();
        t_mask_irq();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule